// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit down-counting channel for an interval timer. A processor reaches it through a byte-wide write/read port. It first writes a control word that picks the output behaviour, how the count is transferred, and whether the count is decimal or binary. It then writes the initial count N as one or two bytes. The channel decrements on every clock cycle in which the count enable input is high. It shapes the `out` pin into one of six waveforms: a terminal-count flag, a retriggerable one-shot, a divide-by-N rate pulse, a square wave, a software-started strobe and a gate-started strobe.

The `gate` input either qualifies counting by its level or starts counting on its rising edge, depending on the mode. A read at the channel's address returns the count as it stands in that cycle. The `CHAN_ID` parameter gives the channel index. That index is both the channel's data address and the select value its control words must carry, so three instances can share one bus.

Top module: `ivl_timer_chan`

## Requirements
- R1: After reset `out` is low, `rdata` is 0, and no counting takes place until a control word and then a count have been written.
- R2: A control word is a write to address 3 whose bits 7:6 equal `CHAN_ID`. Its bits 5:4 give the transfer format, bits 3:1 the mode (110 and 111 act as 2 and 3) and bit 0 selects BCD when set. A control word with another select value, or with format 00, is ignored. A valid control word stops counting and, on the next cycle, sets `out` low for mode 0 and high for every other mode.
- R3: Count writes go to address `CHAN_ID`. Format 01 loads the low byte with a zero high byte. Format 10 loads the high byte with a zero low byte. Format 11 takes the low byte, then the high byte. The first byte stops counting, and counting resumes only after the second byte.
- R4: Mode 0: `out` goes low when a count is written and rises after N ticks. It stays high until the next count write, which drives it low again and restarts counting.
- R5: Mode 1: a rising edge of `gate` (after a count has been written) reloads N and drives `out` low for N ticks. A rising edge during the pulse restarts it.
- R6: Mode 2: starting from the load, `out` is high for N-1 ticks and then low for one tick, and this repeats (N at least 2).
- R7: Mode 3: `out` is high for ceil(N/2) ticks and low for floor(N/2) ticks, and this repeats (N at least 2).
- R8: Mode 4: counting starts at the count write. `out` is low for exactly one tick after the Nth tick and is high at all other times.
- R9: Mode 5: nothing counts until a rising edge of `gate`. From that edge, `out` is low for exactly one tick after the Nth tick.
- R10: In modes 0, 2, 3 and 4 a tick counts only while `gate` is high. With `gate` low the count and `out` hold. In modes 1 and 5 the `gate` level has no effect.
- R11: Binary counting wraps 0 to FFFF. BCD counting decrements each decimal digit, borrowing 0 to 9. A loaded count of 0 stands for 65536 (binary) or 10000 (BCD).
- R12: A read at address `CHAN_ID` returns the live count: the low byte for format 01 and the high byte for format 10. For format 11, reads alternate low then high, starting from low after each control word. With no such read, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| sel | input | 1 | Bus select, active high |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 2 | Register address (3 = control, `CHAN_ID` = count) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational during a read strobe |
| cnt_en | input | 1 | Count enable; each high cycle is one tick |
| gate | input | 1 | Gate input, level or rising-edge use per mode |
| out | output | 1 | Counter output waveform |

## Verification
The write or gate edge that loads the count counts as tick zero. Each later clock edge with `cnt_en` high is one tick, and `out` reflects that tick right after the edge. The bench drives inputs on the falling edge and compares `out` with a function of the mode, N and the ticks it has counted since the load, at the falling edge after each rising edge. `rdata` depends only on the current count and read strobe, so reads are sampled shortly after the strobe is raised, with `cnt_en` low so that the count cannot move under them. A control word's effect on `out` is checked one edge after the write.

// File: rtl/ivl_timer_chan.sv
module ivl_timer_chan #(
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cnt_en,
  input  logic       gate,
  output logic       out
);
  localparam int BW = 8;
  localparam int CW = 2 * BW;
  localparam int ND = CW / 4;

  logic [2:0]    mode_q;
  logic [1:0]    fmt_q;
  logic          bcd_q, run_q, have_n, out_q, wptr_q, rptr_q, gate_q;
  logic [CW-1:0] cnt_q, nval_q;

  function automatic logic [CW-1:0] dec_bcd(input logic [CW-1:0] v);
    logic [CW-1:0] r;
    logic b;
    r = v;
    b = 1'b1;
    for (int i = 0; i < ND; i++)
      if (b) begin
        if (v[4*i+:4] == 4'd0) r[4*i+:4] = 4'd9;
        else begin
          r[4*i+:4] = v[4*i+:4] - 4'd1;
          b = 1'b0;
        end
      end
    return r;
  endfunction

  function automatic logic [CW-1:0] half_bcd(input logic [CW-1:0] v);
    logic [CW-1:0] r;
    logic odd;
    r = '0;
    odd = 1'b0;
    for (int i = ND - 1; i >= 0; i--) begin
      r[4*i+:4] = {1'b0, v[4*i+1+:3]} + (odd ? 4'd5 : 4'd0);
      odd = v[4*i];
    end
    return r;
  endfunction

  wire cw_wr  = sel && wr_en && addr == 2'd3 && wdata[7:6] == CHAN_ID && wdata[5:4] != 2'b00;
  wire ct_wr  = sel && wr_en && addr == CHAN_ID;
  wire ct_rd  = sel && rd_en && addr == CHAN_ID;
  wire first  = ct_wr && fmt_q == 2'b11 && !wptr_q;
  wire ld     = ct_wr && !first;
  wire hw_md  = mode_q == 3'd1 || mode_q == 3'd5;
  wire trig   = hw_md && have_n && gate && !gate_q;
  wire tick   = cnt_en && run_q && (gate || hw_md);
  wire [2:0] new_mode = wdata[2] ? {1'b0, wdata[2:1]} : wdata[3:1];

  logic [CW-1:0] new_n, dcnt, hval;
  always_comb begin
    case (fmt_q)
      2'b01:   new_n = {{BW{1'b0}}, wdata};
      2'b10:   new_n = {wdata, {BW{1'b0}}};
      default: new_n = {wdata, nval_q[BW-1:0]};
    endcase
    dcnt = bcd_q ? dec_bcd(cnt_q) : cnt_q - 1'b1;
    if (nval_q == '0) hval = bcd_q ? {4'd5, {(CW-4){1'b0}}} : {1'b1, {(CW-1){1'b0}}};
    else              hval = bcd_q ? half_bcd(nval_q) : nval_q >> 1;
  end

  assign out = out_q;
  always_comb begin
    rdata = '0;
    if (ct_rd)
      case (fmt_q)
        2'b01:   rdata = cnt_q[BW-1:0];
        2'b10:   rdata = cnt_q[CW-1:BW];
        default: rdata = rptr_q ? cnt_q[CW-1:BW] : cnt_q[BW-1:0];
      endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mode_q <= '0;  fmt_q  <= 2'b01; bcd_q  <= 1'b0;
      cnt_q  <= '0;  nval_q <= '0;    run_q  <= 1'b0;
      have_n <= 1'b0; out_q <= 1'b0;  wptr_q <= 1'b0;
      rptr_q <= 1'b0; gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (ct_rd && fmt_q == 2'b11) rptr_q <= !rptr_q;
      if (cw_wr) begin
        mode_q <= new_mode;
        fmt_q  <= wdata[5:4];
        bcd_q  <= wdata[0];
        run_q  <= 1'b0;
        have_n <= 1'b0;
        wptr_q <= 1'b0;
        rptr_q <= 1'b0;
        out_q  <= new_mode != 3'd0;
      end else if (first) begin
        nval_q[BW-1:0] <= wdata;
        wptr_q <= 1'b1;
        run_q  <= 1'b0;
        if (mode_q == 3'd0) out_q <= 1'b0;
      end else if (ld) begin
        nval_q <= new_n;
        wptr_q <= 1'b0;
        have_n <= 1'b1;
        if (!hw_md) begin
          cnt_q <= new_n;
          run_q <= 1'b1;
          out_q <= mode_q != 3'd0;
        end
      end else if (trig) begin
        cnt_q <= nval_q;
        run_q <= 1'b1;
        out_q <= mode_q == 3'd5;
      end else if (tick) begin
        case (mode_q)
          3'd0: begin
            cnt_q <= dcnt;
            if (cnt_q == 1) out_q <= 1'b1;
          end
          3'd1: begin
            cnt_q <= dcnt;
            if (cnt_q == 1) begin
              out_q <= 1'b1;
              run_q <= 1'b0;
            end
          end
          3'd2: begin
            if (cnt_q == 1) begin
              cnt_q <= nval_q;
              out_q <= 1'b0;
            end else begin
              cnt_q <= dcnt;
              out_q <= 1'b1;
            end
          end
          3'd3: begin
            if (cnt_q == 1) begin
              cnt_q <= nval_q;
              out_q <= 1'b1;
            end else begin
              cnt_q <= dcnt;
              if (dcnt == hval) out_q <= 1'b0;
            end
          end
          default: begin
            if (!out_q) begin
              out_q <= 1'b1;
              run_q <= 1'b0;
            end else begin
              cnt_q <= dcnt;
              if (cnt_q == 1) out_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ivl_timer_chan_chk.sv
module ivl_timer_chan_chk #(
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input logic        clk,
  input logic        rst,
  input logic        sel,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [7:0]  wdata,
  input logic        cnt_en,
  input logic        gate,
  input logic        out,
  input logic [2:0]  mode_q,
  input logic        gate_q,
  input logic        have_n,
  input logic [15:0] cnt_q
);
  wire cw_ok = sel && wr_en && addr == 2'd3 && wdata[7:6] == CHAN_ID && wdata[5:4] != 2'b00;

  a_r2_cw_mode0_low: assert property (@(posedge clk) disable iff (rst)
    (cw_ok && wdata[3:1] == 3'd0) |=> !out);

  a_r2_cw_other_high: assert property (@(posedge clk) disable iff (rst)
    (cw_ok && wdata[3:1] != 3'd0) |=> out);

  a_r4_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd0 && out && !wr_en) |=> out);

  a_r5_trigger_low: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd1 && have_n && gate && !gate_q && !wr_en) |=> !out);

  a_r8_strobe_one_tick: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd4 && !out && cnt_en && gate && !wr_en) |=> out);

  a_r10_gate_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd0 && !gate && !wr_en) |=> $stable(cnt_q));
endmodule

bind ivl_timer_chan ivl_timer_chan_chk #(.CHAN_ID(CHAN_ID)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt_en(cnt_en), .gate(gate), .out(out), .mode_q(mode_q), .gate_q(gate_q),
  .have_n(have_n), .cnt_q(cnt_q)
);

// File: tb/sim_ivl_timer_chan.sv
module sim_ivl_timer_chan;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1, sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic       cnt_en = 1'b0, gate = 1'b1, out;
  int         n_chk = 0, n_fail = 0;

  ivl_timer_chan #(.CHAN_ID(2'd0)) u0 (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .gate(gate), .out(out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit exp_out(int m, int n, int t);
    case (m)
      0, 1:    return t >= n;
      2:       return t == 0 || (t % n) != 0;
      3:       return (t % n) < (n + 1) / 2;
      default: return t != n;
    endcase
  endfunction

  function automatic int to_bcd(int v);
    int r = 0;
    for (int i = 0; i < 4; i++) begin
      r = r | ((v % 10) << (4 * i));
      v = v / 10;
    end
    return r;
  endfunction

  function automatic logic [7:0] cw(int sc, int fmt, int m, int bcd);
    return {sc[1:0], fmt[1:0], m[2:0], bcd[0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; sel = 1'b1; wr_en = 1'b1;
    cyc();
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    addr = 2'd0; sel = 1'b1; rd_en = 1'b1;
    #1 b = rdata;
    cyc();
    sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic run_wave(int m, int n, int len, string tag);
    for (int t = 0; t <= len; t++) begin
      chk(out == exp_out(m, n, t), tag, out, exp_out(m, n, t));
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] lo, hi;
    int n, k, ticks, dv;
    bit en, g;
    void'($urandom(32'h1f3a));
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk(out == 1'b0, "R1 reset out", out, 0);
    chk(rdata == 8'd0, "R1 reset rdata", rdata, 0);
    cnt_en = 1'b1;
    repeat (4) cyc();
    chk(out == 1'b0, "R1 idle before load", out, 0);

    // R4 / R3 format 11: counting waits for the high byte
    bus_wr(2'd3, cw(0, 3, 0, 0));
    chk(out == 1'b0, "R2 mode0 cw out", out, 0);
    bus_wr(2'd0, 8'd4);
    repeat (6) cyc();
    chk(out == 1'b0, "R3 no count after low byte", out, 0);
    bus_wr(2'd0, 8'd0);
    run_wave(0, 4, 7, "R4 mode0 N=4");
    bus_wr(2'd0, 8'd3);
    bus_wr(2'd0, 8'd0);
    run_wave(0, 3, 5, "R4 mode0 reload");

    // R10 gate pause and R12 read order
    bus_wr(2'd0, 8'd20);
    bus_wr(2'd0, 8'd0);
    repeat (5) cyc();
    gate = 1'b0;
    repeat (3) cyc();
    cnt_en = 1'b0;
    gate = 1'b1;
    rd_byte(lo);
    rd_byte(hi);
    chk(lo == 8'd15, "R10 paused count low", lo, 15);
    chk(hi == 8'd0, "R12 high byte second", hi, 0);
    rd_byte(lo);
    chk(lo == 8'd15, "R12 alternation back to low", lo, 15);
    chk(out == 1'b0, "R10 out held low", out, 0);
    rd_byte(hi);

    // R10 random enable and gate in mode 0
    bus_wr(2'd3, cw(0, 1, 0, 0));
    for (int r = 0; r < 4; r++) begin
      n = 3 + int'($urandom % 30);
      bus_wr(2'd0, n[7:0]);
      ticks = 0;
      for (int c = 0; c < 120; c++) begin
        chk(out == (ticks >= n), "R10 random tick mode0", out, ticks >= n);
        en = 1'($urandom % 2);
        g = ($urandom % 4) != 0;
        cnt_en = en; gate = g;
        cyc();
        if (en && g) ticks++;
      end
      gate = 1'b1;
    end

    // R11 BCD and binary wrap, R12 live read
    bus_wr(2'd3, cw(0, 3, 0, 1));
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd0, 8'h01);
    cnt_en = 1'b1; cyc(); cnt_en = 1'b0;
    rd_byte(lo); rd_byte(hi);
    chk({hi, lo} == 16'h0099, "R11 BCD 100-1", {hi, lo}, 16'h0099);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd0, 8'h00);
    cnt_en = 1'b1; cyc(); cnt_en = 1'b0;
    rd_byte(lo); rd_byte(hi);
    chk({hi, lo} == 16'h9999, "R11 BCD zero wraps", {hi, lo}, 16'h9999);
    for (int r = 0; r < 6; r++) begin
      dv = 20 + int'($urandom % 9980);
      k = 1 + int'($urandom % 15);
      n = to_bcd(dv);
      bus_wr(2'd0, n[7:0]);
      bus_wr(2'd0, n[15:8]);
      cnt_en = 1'b1; repeat (k) cyc(); cnt_en = 1'b0;
      rd_byte(lo); rd_byte(hi);
      chk({hi, lo} == 16'(to_bcd(dv - k)), "R11 BCD random", {hi, lo}, to_bcd(dv - k));
    end
    bus_wr(2'd3, cw(0, 3, 0, 0));
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd0, 8'h00);
    cnt_en = 1'b1; cyc(); cnt_en = 1'b0;
    rd_byte(lo); rd_byte(hi);
    chk({hi, lo} == 16'hFFFF, "R11 binary zero wraps", {hi, lo}, 16'hFFFF);
    bus_wr(2'd3, cw(0, 2, 0, 0));
    bus_wr(2'd0, 8'h12);
    rd_byte(hi);
    chk(hi == 8'h12, "R3 R12 high-byte format", hi, 8'h12);

    // R6 / R7 rate and square
    cnt_en = 1'b1;
    for (int m = 2; m <= 3; m++)
      for (int r = 0; r < 6; r++) begin
        n = (r == 0) ? 6 : (r == 1) ? 7 : 2 + int'($urandom % 15);
        bus_wr(2'd3, cw(0, 1, m + ((r == 2) ? 4 : 0), 0));
        chk(out == 1'b1, "R2 non-zero mode out high", out, 1);
        bus_wr(2'd0, n[7:0]);
        run_wave(m, n, 3 * n, m == 2 ? "R6 rate wave" : "R7 square wave");
      end

    // R8 software strobe
    bus_wr(2'd3, cw(0, 1, 4, 0));
    bus_wr(2'd0, 8'd5);
    run_wave(4, 5, 9, "R8 strobe");

    // R2 ignored control words
    bus_wr(2'd3, cw(1, 1, 0, 0));
    chk(out == 1'b1, "R2 other select ignored", out, 1);
    bus_wr(2'd3, cw(0, 0, 0, 0));
    chk(out == 1'b1, "R2 format 00 ignored", out, 1);

    // R9 hardware strobe
    bus_wr(2'd3, cw(0, 1, 5, 0));
    gate = 1'b0;
    bus_wr(2'd0, 8'd4);
    repeat (6) cyc();
    chk(out == 1'b1, "R9 waits for gate", out, 1);
    gate = 1'b1; cyc();
    run_wave(5, 4, 8, "R9 gate strobe");

    // R5 one-shot with retrigger, gate level ignored
    bus_wr(2'd3, cw(0, 1, 1, 0));
    gate = 1'b0;
    bus_wr(2'd0, 8'd4);
    chk(out == 1'b1, "R5 idle high", out, 1);
    gate = 1'b1; cyc();
    chk(out == 1'b0, "R5 triggered low", out, 0);
    cyc();
    gate = 1'b0; cyc();
    chk(out == 1'b0, "R5 gate low ignored", out, 0);
    gate = 1'b1; cyc();
    run_wave(1, 4, 6, "R5 retriggered pulse");

    bus_wr(2'd3, cw(0, 1, 0, 0));
    chk(out == 1'b0, "R2 valid cw mode0", out, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule